// File: doc/BRIEF.md
# SMBus packet error check engine

This block sits on the target side of an SMBus/PMBus link. It receives the byte stream of a transaction after the bus layer has deserialized it. It keeps one CRC-8 over the whole message. The message includes the write address, the command, the address that follows a repeated start, and every data byte in either direction. The bus layer marks the start of a transaction, each byte, the direction of that byte, and the final byte the target sends.

The block handles writes and reads differently:

- **Writes.** The command decoder supplies the number of message bytes it expects. A host byte beyond that count is taken as the packet error code and compared with the running CRC. A mismatch is reported as a one-cycle pulse, which the alert logic can treat as a communication error. A write that ends without the extra byte is accepted without a check.
- **Reads.** Once the target's last data byte has been fed in, the running CRC is flagged valid. The bus layer then sends it as the trailing byte.

Top module: `smbus_pec_engine`

## Requirements
- R1: The CRC uses the generator x^8 + x^2 + x + 1 (0x07) and folds in one byte per `byte_vld_i` strobe, most significant bit first. `pec_o` shows the register in the cycle after the strobe. Example: the ASCII bytes "123456789" give 0xF4.
- R2: `start_i` sets the CRC to 0x00 and restarts byte counting. A byte strobed in the same cycle as `start_i` is discarded.
- R3: `rstart_i` leaves the CRC unchanged. After a repeated start, every host byte of the transaction is a message byte and is never taken as a PEC.
- R4: With `wr_len_i` = N, host bytes 1..N after START are message bytes, counting the address byte. Host byte N+1, when it comes before any repeated start, is the received PEC and is not folded into the CRC. In the next cycle `pec_chk_o` is high for exactly one cycle.
- R5: `pec_err_o` pulses together with `pec_chk_o` when the received PEC differs from the CRC of the preceding message bytes, and stays low when they match.
- R6: A write that stops after N host bytes produces no `pec_chk_o` or `pec_err_o` pulse.
- R7: Host bytes that follow a received PEC are ignored. The CRC does not change and no further check pulse appears.
- R8: A target byte strobed with `tx_last_i` raises `pec_vld_o` in the next cycle. `pec_o` then holds the CRC of the whole message, that byte included.
- R9: A target byte strobed while `pec_vld_o` is high is the transmitted PEC. It is not folded into the CRC, and it clears `pec_vld_o` in the next cycle.
- R10: `start_i` clears `pec_vld_o` in the next cycle.
- R11: After reset, `pec_o` is 0x00 and `pec_vld_o`, `pec_chk_o` and `pec_err_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | START seen on the bus (one-cycle strobe) |
| rstart_i | input | 1 | Repeated START seen (one-cycle strobe) |
| byte_vld_i | input | 1 | A byte is present on `byte_i` |
| byte_i | input | 8 | Byte value |
| from_host_i | input | 1 | 1: host drove the byte, 0: target drove it |
| tx_last_i | input | 1 | With a target byte: last data byte of the read |
| wr_len_i | input | CNT_W | Host message bytes expected on a write, counting the address |
| pec_o | output | 8 | Running CRC; the PEC to transmit when `pec_vld_o` is high |
| pec_vld_o | output | 1 | `pec_o` is the final PEC of a read |
| pec_chk_o | output | 1 | One-cycle pulse: a received PEC was checked |
| pec_err_o | output | 1 | One-cycle pulse with `pec_chk_o`: the received PEC was wrong |

## Verification
The CRC datapath is driven with several byte patterns, and each one rules out a different kind of fault:

- The standard nine-byte ASCII string pins down the polynomial and the bit order.
- An all-zero run exposes a wrong initial value.
- A single 0xFF byte exposes a wrong reflection or a wrong shift.
- A mixed six-byte run exposes carries that are dropped between bytes.

Further transactions separate the byte roles from each other:

- A write with a correct PEC and a write with a corrupted PEC separate the check pulse from the error pulse.
- A write without a PEC and trailing host bytes after a received PEC show that extra bytes are neither checked nor accumulated.
- A read whose host byte count would match `wr_len_i` after the repeated start shows that the read address is accumulated rather than checked.
- The target's PEC byte is shown to be excluded from the CRC.

// File: rtl/smbus_pec_pkg.sv
package smbus_pec_pkg;

    // Role a strobed byte plays in the current transaction
    typedef enum logic [1:0] {
        BK_SKIP   = 2'd0,   // not folded, no action
        BK_MSG    = 2'd1,   // message byte, folded into CRC
        BK_PEC_RX = 2'd2,   // PEC sent by host, compared
        BK_PEC_TX = 2'd3    // PEC sent by target, not folded
    } byte_kind_e;

    typedef struct packed {
        logic [7:0] data;
        logic       from_host;
        logic       tx_last;
    } byte_evt_t;

    // One byte of CRC-8, MSB first, non-reflected, no final xor
    function automatic logic [7:0] crc8_fold(input logic [7:0] crc,
                                             input logic [7:0] din,
                                             input logic [7:0] poly);
        logic [7:0] c;
        c = crc ^ din;
        for (int k = 0; k < 8; k++) begin
            c = c[7] ? ((c << 1) ^ poly) : (c << 1);
        end
        return c;
    endfunction

endpackage

// File: rtl/pec_byte_class.sv
module pec_byte_class
    import smbus_pec_pkg::*;
#(
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic             rstart_i,
    input  logic             byte_vld_i,
    input  logic             from_host_i,
    input  logic             tx_last_i,
    input  logic [CNT_W-1:0] wr_len_i,
    output byte_kind_e       kind_o,
    output logic             pec_vld_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic [CNT_W-1:0] host_cnt_q;
    logic             rs_seen_q;
    logic             rx_done_q;
    logic             pec_vld_q;

    always_comb begin
        kind_o = BK_SKIP;
        if (byte_vld_i && !start_i) begin
            if (from_host_i) begin
                if (rx_done_q)
                    kind_o = BK_SKIP;
                else if (!rs_seen_q && !rstart_i && host_cnt_q == wr_len_i)
                    kind_o = BK_PEC_RX;
                else
                    kind_o = BK_MSG;
            end else begin
                kind_o = pec_vld_q ? BK_PEC_TX : BK_MSG;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst || start_i) begin
            host_cnt_q <= '0;
            rs_seen_q  <= 1'b0;
            rx_done_q  <= 1'b0;
            pec_vld_q  <= 1'b0;
        end else begin
            if (rstart_i)
                rs_seen_q <= 1'b1;
            unique case (kind_o)
                BK_MSG: begin
                    if (from_host_i) begin
                        if (!rs_seen_q && host_cnt_q != CNT_MAX)
                            host_cnt_q <= host_cnt_q + 1'b1;
                    end else if (tx_last_i) begin
                        pec_vld_q <= 1'b1;
                    end
                end
                BK_PEC_RX: rx_done_q <= 1'b1;
                BK_PEC_TX: pec_vld_q <= 1'b0;
                default: ;
            endcase
        end
    end

    assign pec_vld_o = pec_vld_q;

endmodule

// File: rtl/pec_crc_acc.sv
module pec_crc_acc
    import smbus_pec_pkg::*;
#(
    parameter logic [7:0] POLY = 8'h07,
    parameter logic [7:0] INIT = 8'h00
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       start_i,
    input  byte_kind_e kind_i,
    input  logic [7:0] data_i,
    output logic [7:0] crc_o,
    output logic       chk_o,
    output logic       err_o
);
    logic [7:0] crc_q;
    logic       chk_q;
    logic       err_q;

    always_ff @(posedge clk) begin
        if (rst || start_i) begin
            crc_q <= INIT;
            chk_q <= 1'b0;
            err_q <= 1'b0;
        end else begin
            chk_q <= 1'b0;
            err_q <= 1'b0;
            unique case (kind_i)
                BK_MSG:    crc_q <= crc8_fold(crc_q, data_i, POLY);
                BK_PEC_RX: begin
                    chk_q <= 1'b1;
                    err_q <= (data_i != crc_q);
                end
                default: ;
            endcase
        end
    end

    assign crc_o = crc_q;
    assign chk_o = chk_q;
    assign err_o = err_q;

endmodule

// File: rtl/smbus_pec_engine.sv
module smbus_pec_engine
    import smbus_pec_pkg::*;
#(
    parameter logic [7:0] CRC_POLY = 8'h07,
    parameter logic [7:0] CRC_INIT = 8'h00,
    parameter int         CNT_W    = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic             rstart_i,
    input  logic             byte_vld_i,
    input  logic [7:0]       byte_i,
    input  logic             from_host_i,
    input  logic             tx_last_i,
    input  logic [CNT_W-1:0] wr_len_i,
    output logic [7:0]       pec_o,
    output logic             pec_vld_o,
    output logic             pec_chk_o,
    output logic             pec_err_o
);
    byte_evt_t  evt;
    byte_kind_e kind;

    assign evt = '{data: byte_i, from_host: from_host_i, tx_last: tx_last_i};

    pec_byte_class #(.CNT_W(CNT_W)) u_class (
        .clk         (clk),
        .rst         (rst),
        .start_i     (start_i),
        .rstart_i    (rstart_i),
        .byte_vld_i  (byte_vld_i),
        .from_host_i (evt.from_host),
        .tx_last_i   (evt.tx_last),
        .wr_len_i    (wr_len_i),
        .kind_o      (kind),
        .pec_vld_o   (pec_vld_o)
    );

    pec_crc_acc #(.POLY(CRC_POLY), .INIT(CRC_INIT)) u_acc (
        .clk     (clk),
        .rst     (rst),
        .start_i (start_i),
        .kind_i  (kind),
        .data_i  (evt.data),
        .crc_o   (pec_o),
        .chk_o   (pec_chk_o),
        .err_o   (pec_err_o)
    );

endmodule

// File: rtl/smbus_pec_engine_chk.sv
module smbus_pec_engine_chk (
    input logic       clk,
    input logic       rst,
    input logic       start_i,
    input logic       rstart_i,
    input logic       byte_vld_i,
    input logic       from_host_i,
    input logic       tx_last_i,
    input logic [7:0] pec_o,
    input logic       pec_vld_o,
    input logic       pec_chk_o,
    input logic       pec_err_o
);
    assert_start_clears_R2: assert property (@(posedge clk) disable iff (rst)
        start_i |=> pec_o == 8'h00);

    assert_idle_hold_R1: assert property (@(posedge clk) disable iff (rst)
        (!byte_vld_i && !start_i) |=> $stable(pec_o));

    assert_rstart_keeps_R3: assert property (@(posedge clk) disable iff (rst)
        (rstart_i && !byte_vld_i && !start_i) |=> $stable(pec_o));

    assert_chk_single_R4: assert property (@(posedge clk) disable iff (rst)
        pec_chk_o |=> !pec_chk_o);

    assert_err_with_chk_R5: assert property (@(posedge clk) disable iff (rst)
        pec_err_o |-> pec_chk_o);

    assert_vld_rise_R8: assert property (@(posedge clk) disable iff (rst)
        (byte_vld_i && !from_host_i && tx_last_i && !start_i && !pec_vld_o) |=> pec_vld_o);

    assert_tx_pec_excluded_R9: assert property (@(posedge clk) disable iff (rst)
        (byte_vld_i && !from_host_i && pec_vld_o && !start_i) |=> ($stable(pec_o) && !pec_vld_o));

    assert_start_drops_vld_R10: assert property (@(posedge clk) disable iff (rst)
        start_i |=> !pec_vld_o);
endmodule

bind smbus_pec_engine smbus_pec_engine_chk u_pec_chk (
    .clk         (clk),
    .rst         (rst),
    .start_i     (start_i),
    .rstart_i    (rstart_i),
    .byte_vld_i  (byte_vld_i),
    .from_host_i (from_host_i),
    .tx_last_i   (tx_last_i),
    .pec_o       (pec_o),
    .pec_vld_o   (pec_vld_o),
    .pec_chk_o   (pec_chk_o),
    .pec_err_o   (pec_err_o)
);

// File: tb/smbus_pec_engine_bench.sv
`timescale 1ns/1ps
module smbus_pec_engine_bench;
    localparam int CNT_W = 6;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             start_i = 1'b0;
    logic             rstart_i = 1'b0;
    logic             byte_vld_i = 1'b0;
    logic [7:0]       byte_i = 8'h00;
    logic             from_host_i = 1'b0;
    logic             tx_last_i = 1'b0;
    logic [CNT_W-1:0] wr_len_i = '1;
    logic [7:0]       pec_o;
    logic             pec_vld_o;
    logic             pec_chk_o;
    logic             pec_err_o;

    int checks = 0;
    int fails  = 0;
    logic [7:0] model;

    always #2.5 clk = ~clk;   // 200 MHz

    smbus_pec_engine #(.CNT_W(CNT_W)) u_smbus_pec_engine (
        .clk(clk), .rst(rst), .start_i(start_i), .rstart_i(rstart_i),
        .byte_vld_i(byte_vld_i), .byte_i(byte_i), .from_host_i(from_host_i),
        .tx_last_i(tx_last_i), .wr_len_i(wr_len_i), .pec_o(pec_o),
        .pec_vld_o(pec_vld_o), .pec_chk_o(pec_chk_o), .pec_err_o(pec_err_o)
    );

    // Stimulus table: bytes left-aligned, count, fed as host bytes with no PEC
    localparam int NV = 4;
    localparam logic [71:0] VB [NV] = '{
        72'h31_32_33_34_35_36_37_38_39,
        72'hFF_00_00_00_00_00_00_00_00,
        72'h00_00_00_00_00_00_00_00_00,
        72'hB6_01_80_A5_5A_C3_00_00_00
    };
    localparam int VL [NV] = '{9, 1, 4, 6};

    // Bit-serial reference: shift one data bit at a time into the feedback
    function automatic logic [7:0] ref_fold(input logic [7:0] c, input logic [7:0] d);
        logic [7:0] r;
        logic fb;
        r = c;
        for (int i = 7; i >= 0; i--) begin
            fb = r[7] ^ d[i];
            r = {r[6:0], 1'b0};
            if (fb) r = r ^ 8'b0000_0111;
        end
        return r;
    endfunction

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Drive one strobe at a negedge, return at the next negedge (outputs settled)
    task automatic put(input logic [7:0] b, input logic host, input logic last);
        byte_vld_i = 1'b1; byte_i = b; from_host_i = host; tx_last_i = last;
        @(negedge clk);
        byte_vld_i = 1'b0; tx_last_i = 1'b0;
    endtask

    task automatic do_start();
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        model = 8'h00;
    endtask

    task automatic host_msg(input logic [7:0] b);
        put(b, 1'b1, 1'b0);
        model = ref_fold(model, b);
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL R11: watchdog expired actual=running expected=done");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R11 reset state
        check("R11 pec_o", pec_o, 8'h00);
        check("R11 flags", {5'd0, pec_vld_o, pec_chk_o, pec_err_o}, 8'h00);

        // R1 table walk
        for (int v = 0; v < NV; v++) begin
            wr_len_i = '1;
            do_start();
            for (int k = 0; k < VL[v]; k++) begin
                host_msg(VB[v][71-8*k -: 8]);
            end
            check("R1 table crc", pec_o, model);
            if (v == 0) check("R1 check value 123456789", pec_o, 8'hF4);
        end

        // R2: START with a byte in the same cycle discards the byte
        start_i = 1'b1; byte_vld_i = 1'b1; byte_i = 8'h5A; from_host_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0; byte_vld_i = 1'b0;
        check("R2 start discards byte", pec_o, 8'h00);

        // R4/R5: write addr+cmd+data, correct PEC
        wr_len_i = 6'd3;
        do_start();
        host_msg(8'hB6); host_msg(8'h01); host_msg(8'h80);
        put(model, 1'b1, 1'b0);
        check("R4 chk pulse", {7'd0, pec_chk_o}, 8'h01);
        check("R5 no err on good PEC", {7'd0, pec_err_o}, 8'h00);
        check("R4 PEC not folded", pec_o, model);
        // R7: trailing host byte ignored
        put(8'h3C, 1'b1, 1'b0);
        check("R4 pulse one cycle", {7'd0, pec_chk_o}, 8'h00);
        check("R7 trailing byte ignored", pec_o, model);

        // R5: corrupted PEC
        do_start();
        host_msg(8'hB6); host_msg(8'h01); host_msg(8'h80);
        put(model ^ 8'h10, 1'b1, 1'b0);
        check("R5 err pulse", {6'd0, pec_chk_o, pec_err_o}, 8'h03);
        @(negedge clk);
        check("R5 err one cycle", {6'd0, pec_chk_o, pec_err_o}, 8'h00);

        // R6: write without PEC
        do_start();
        host_msg(8'hB6); host_msg(8'h21); host_msg(8'h44);
        repeat (3) @(negedge clk);
        check("R6 no check without PEC", {6'd0, pec_chk_o, pec_err_o}, 8'h00);
        check("R6 crc kept", pec_o, model);

        // R3/R8/R9: read with repeated start; wr_len 2 would match read addr
        wr_len_i = 6'd2;
        do_start();
        host_msg(8'hB6); host_msg(8'h8B);
        rstart_i = 1'b1;
        @(negedge clk);
        rstart_i = 1'b0;
        check("R3 rstart keeps crc", pec_o, model);
        host_msg(8'hB7);
        check("R3 read addr folded, not checked", {7'd0, pec_chk_o}, 8'h00);
        check("R3 crc after read addr", pec_o, model);
        put(8'h34, 1'b0, 1'b0); model = ref_fold(model, 8'h34);
        check("R8 no vld before last", {7'd0, pec_vld_o}, 8'h00);
        put(8'h12, 1'b0, 1'b1); model = ref_fold(model, 8'h12);
        check("R8 vld after last", {7'd0, pec_vld_o}, 8'h01);
        check("R8 pec value", pec_o, model);
        put(pec_o, 1'b0, 1'b0);
        check("R9 tx PEC not folded", pec_o, model);
        check("R9 vld cleared", {7'd0, pec_vld_o}, 8'h00);

        // R10: START while vld high
        do_start();
        host_msg(8'hB7);
        put(8'h99, 1'b0, 1'b1);
        check("R8 vld set again", {7'd0, pec_vld_o}, 8'h01);
        do_start();
        check("R10 start clears vld", {7'd0, pec_vld_o}, 8'h00);

        finish_run();
    end
endmodule